// File: doc/BRIEF.md
# Automatic RTS/CTS Flow Controller

This block handles hardware handshaking for one serial channel. On the receive side it watches how full the receive FIFO is and drives the RTS line. RTS is a request-to-send line where 0 means "send more" and 1 means "hold off". The controller asks the far end to pause when the FIFO climbs one trigger step above the programmed threshold. It lets traffic resume only once the FIFO has drained below the step beneath that threshold. The band between the two steps gives hysteresis, so RTS does not chatter around a single compare point. The same path raises a receive-threshold interrupt while automatic RTS is on and the fill level is at or above the programmed threshold.

On the transmit side, the incoming CTS line first passes through a two-flop synchronizer. The block then turns it into a transmit-permit flag. The transmitter signals the start of each character by pulsing a boundary strobe, and the permit flag is refreshed only on that strobe. A character already on the wire therefore always completes. When automatic control is disabled, RTS is taken from a manual input and the permit flag is granted at each boundary.

Top module: `flowctl_top`

## Requirements
- R1: During and right after synchronous reset, `rts_o` is 1, `rx_thr_irq_o` is 0 and `tx_permit_o` is 1. The internal RTS hold state is cleared, so it reads as 0.
- R2: With `auto_rts_en_i` = 0, `rts_o` equals `rts_manual_i` one clock later. `rx_thr_irq_o` is 0, and the RTS hold state is cleared to 0.
- R3: The trigger levels are 8, 16, 24 and 28, selected by `trig_sel_i` values 0 to 3. With `auto_rts_en_i` = 1, `rx_thr_irq_o` is 1 one clock after a cycle with `rx_count_i` >= the selected level, and 0 otherwise.
- R4: With `auto_rts_en_i` = 1, a count at or above the next level up (index `trig_sel_i`+1) makes `rts_o` 1 one clock later.
- R5: With `auto_rts_en_i` = 1, `rts_o` returns to 0 one clock after a count below the next level down (index `trig_sel_i`-1). For counts between the two levels, `rts_o` keeps its previous value.
- R6: The adjacent level index saturates at the ends of the table. For selection 3 the upper level is 28, and for selection 0 the lower level is 8.
- R7: With `auto_cts_en_i` = 1, a boundary strobe sets `tx_permit_o` to the inverse of the synchronized CTS, one clock after the strobe. CTS at 1 means stop and CTS at 0 means go.
- R8: While `tx_boundary_i` is 0, `tx_permit_o` does not change, whatever CTS does.
- R9: With `auto_cts_en_i` = 0, a boundary strobe sets `tx_permit_o` to 1.
- R10: A change on `cts_i` reaches `tx_permit_o` three clocks later when the boundary strobe is held high. After two clocks the old value is still shown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_count_i | input | CNT_W (6) | Current receive FIFO fill count |
| trig_sel_i | input | 2 | Programmed trigger-level index |
| auto_rts_en_i | input | 1 | Enable automatic RTS |
| auto_cts_en_i | input | 1 | Enable automatic CTS gating |
| rts_manual_i | input | 1 | RTS value used when automatic RTS is off |
| cts_i | input | 1 | Asynchronous CTS line from the far end |
| tx_boundary_i | input | 1 | Transmitter is at a character start |
| rts_o | output | 1 | RTS line (1 = hold off) |
| rx_thr_irq_o | output | 1 | Receive-threshold interrupt |
| tx_permit_o | output | 1 | Transmitter may start the next character |

## Verification
The hardest state to reach is the hysteresis band. There RTS depends on the direction the count arrived from, not on the count itself. Each trigger selection is therefore swept with the count ramping from empty to full and then back down, so every count in the band is seen with RTS both held high and released low. Before each ramp, automatic RTS is switched off for a cycle to clear the hold state.

// File: rtl/flowctl_pkg.sv
package flowctl_pkg;
  localparam int NUM_LVL = 4;

  function automatic int unsigned idx_up(input int unsigned idx, input int unsigned top);
    return (idx >= top) ? top : idx + 1;
  endfunction

  function automatic int unsigned idx_dn(input int unsigned idx);
    return (idx == 0) ? 0 : idx - 1;
  endfunction
endpackage

// File: rtl/fc_sync2.sv
module fc_sync2 #(
  parameter int STAGES = 2,
  parameter bit RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (rst) chain_q <= {STAGES{RST_VAL}};
    else     chain_q <= {chain_q[STAGES-2:0], d_i};
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/fc_rts_ctrl.sv
module fc_rts_ctrl
  import flowctl_pkg::*;
#(
  parameter int CNT_W = 6,
  parameter int SEL_W = 2,
  parameter int LVL0  = 8,
  parameter int LVL1  = 16,
  parameter int LVL2  = 24,
  parameter int LVL3  = 28
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] count_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             auto_en_i,
  input  logic             manual_i,
  output logic             rts_o,
  output logic             irq_o
);
  localparam int TOP = NUM_LVL - 1;

  logic [CNT_W-1:0] lvl_tab [NUM_LVL];
  logic [CNT_W-1:0] prog_lvl, up_lvl, dn_lvl;
  logic             hold_q, hold_nx, rts_q, irq_q;

  assign lvl_tab[0] = CNT_W'(LVL0);
  assign lvl_tab[1] = CNT_W'(LVL1);
  assign lvl_tab[2] = CNT_W'(LVL2);
  assign lvl_tab[3] = CNT_W'(LVL3);

  always_comb begin
    prog_lvl = lvl_tab[sel_i];
    up_lvl   = lvl_tab[SEL_W'(idx_up(int'(sel_i), TOP))];
    dn_lvl   = lvl_tab[SEL_W'(idx_dn(int'(sel_i)))];
    hold_nx  = hold_q;
    if (!auto_en_i)              hold_nx = 1'b0;
    else if (count_i >= up_lvl)  hold_nx = 1'b1;
    else if (count_i <  dn_lvl)  hold_nx = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q <= 1'b0;
      rts_q  <= 1'b1;
      irq_q  <= 1'b0;
    end else begin
      hold_q <= hold_nx;
      rts_q  <= auto_en_i ? hold_nx : manual_i;
      irq_q  <= auto_en_i && (count_i >= prog_lvl);
    end
  end

  assign rts_o = rts_q;
  assign irq_o = irq_q;
endmodule

// File: rtl/fc_cts_gate.sv
module fc_cts_gate #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic cts_i,
  input  logic auto_en_i,
  input  logic boundary_i,
  output logic permit_o
);
  logic cts_s, permit_q;

  fc_sync2 #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i (cts_i),
    .q_o (cts_s)
  );

  always_ff @(posedge clk) begin
    if (rst)             permit_q <= 1'b1;
    else if (boundary_i) permit_q <= !(auto_en_i && cts_s);
  end

  assign permit_o = permit_q;
endmodule

// File: rtl/flowctl_top.sv
module flowctl_top #(
  parameter int FIFO_DEPTH  = 32,
  parameter int LVL0        = 8,
  parameter int LVL1        = 16,
  parameter int LVL2        = 24,
  parameter int LVL3        = 28,
  parameter int SYNC_STAGES = 2,
  localparam int CNT_W      = $clog2(FIFO_DEPTH + 1),
  localparam int SEL_W      = $clog2(flowctl_pkg::NUM_LVL)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] rx_count_i,
  input  logic [SEL_W-1:0] trig_sel_i,
  input  logic             auto_rts_en_i,
  input  logic             auto_cts_en_i,
  input  logic             rts_manual_i,
  input  logic             cts_i,
  input  logic             tx_boundary_i,
  output logic             rts_o,
  output logic             rx_thr_irq_o,
  output logic             tx_permit_o
);
  fc_rts_ctrl #(
    .CNT_W(CNT_W), .SEL_W(SEL_W),
    .LVL0(LVL0), .LVL1(LVL1), .LVL2(LVL2), .LVL3(LVL3)
  ) u_rts (
    .clk       (clk),
    .rst       (rst),
    .count_i   (rx_count_i),
    .sel_i     (trig_sel_i),
    .auto_en_i (auto_rts_en_i),
    .manual_i  (rts_manual_i),
    .rts_o     (rts_o),
    .irq_o     (rx_thr_irq_o)
  );

  fc_cts_gate #(.SYNC_STAGES(SYNC_STAGES)) u_cts (
    .clk        (clk),
    .rst        (rst),
    .cts_i      (cts_i),
    .auto_en_i  (auto_cts_en_i),
    .boundary_i (tx_boundary_i),
    .permit_o   (tx_permit_o)
  );
endmodule

// File: rtl/flowctl_checker.sv
module flowctl_checker #(
  parameter int CNT_W = 6,
  parameter int SEL_W = 2,
  parameter int LVL0  = 8,
  parameter int LVL1  = 16,
  parameter int LVL2  = 24,
  parameter int LVL3  = 28
) (
  input logic             clk,
  input logic             rst,
  input logic [CNT_W-1:0] rx_count_i,
  input logic [SEL_W-1:0] trig_sel_i,
  input logic             auto_rts_en_i,
  input logic             auto_cts_en_i,
  input logic             rts_manual_i,
  input logic             tx_boundary_i,
  input logic             rts_o,
  input logic             rx_thr_irq_o,
  input logic             tx_permit_o
);
  function automatic int lvl_of(input int i);
    case (i)
      0:       return LVL0;
      1:       return LVL1;
      2:       return LVL2;
      default: return LVL3;
    endcase
  endfunction

  int cur_lvl, hi_lvl, lo_lvl;
  always_comb begin
    cur_lvl = lvl_of(int'(trig_sel_i));
    hi_lvl  = lvl_of((int'(trig_sel_i) == 3) ? 3 : int'(trig_sel_i) + 1);
    lo_lvl  = lvl_of((int'(trig_sel_i) == 0) ? 0 : int'(trig_sel_i) - 1);
  end

  assert_manual_rts_R2: assert property (@(posedge clk) disable iff (rst)
    !auto_rts_en_i |=> (rts_o == $past(rts_manual_i)) && !rx_thr_irq_o);

  assert_irq_level_R3: assert property (@(posedge clk) disable iff (rst)
    (auto_rts_en_i && int'(rx_count_i) >= cur_lvl) |=> rx_thr_irq_o);

  assert_rts_high_R4: assert property (@(posedge clk) disable iff (rst)
    (auto_rts_en_i && int'(rx_count_i) >= hi_lvl) |=> rts_o);

  assert_rts_low_R5: assert property (@(posedge clk) disable iff (rst)
    (auto_rts_en_i && int'(rx_count_i) < lo_lvl) |=> !rts_o);

  assert_permit_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !tx_boundary_i |=> $stable(tx_permit_o));

  assert_permit_free_R9: assert property (@(posedge clk) disable iff (rst)
    (tx_boundary_i && !auto_cts_en_i) |=> tx_permit_o);
endmodule

bind flowctl_top flowctl_checker #(
  .CNT_W(CNT_W), .SEL_W(SEL_W),
  .LVL0(LVL0), .LVL1(LVL1), .LVL2(LVL2), .LVL3(LVL3)
) u_chk (.*);

// File: tb/flowctl_top_bench.sv
module flowctl_top_bench;
  localparam int CW = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [CW-1:0] cnt = '0;
  logic [1:0] sel = '0;
  logic a_rts = 1'b0, a_cts = 1'b0, man = 1'b0, cts = 1'b0, bnd = 1'b0;
  logic rts, irq, permit;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  flowctl_top u_flowctl_top (
    .clk(clk), .rst(rst), .rx_count_i(cnt), .trig_sel_i(sel),
    .auto_rts_en_i(a_rts), .auto_cts_en_i(a_cts), .rts_manual_i(man),
    .cts_i(cts), .tx_boundary_i(bnd), .rts_o(rts), .rx_thr_irq_o(irq),
    .tx_permit_o(permit)
  );

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic chk(input string req, input logic act, input logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0b expected %0b (sel=%0d cnt=%0d)", req, act, exp, sel, cnt);
    end
  endtask

  function automatic int lvl(input int i);
    return 8 * (i + 1) - ((i == 3) ? 4 : 0);
  endfunction

  initial begin
    #3_000_000;
    if (!done) begin
      n_fail++; n_run++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    int hold;
    step(); step();
    chk("R1 rts", rts, 1'b1);
    chk("R1 irq", irq, 1'b0);
    chk("R1 permit", permit, 1'b1);
    rst = 1'b0;

    // R2: manual RTS path
    for (int k = 0; k < 6; k++) begin
      man = k[0]; cnt = CW'(k * 6);
      step();
      chk("R2 rts", rts, man);
      chk("R2 irq", irq, 1'b0);
    end

    // R3/R4/R5/R6: hysteresis sweeps for every selection
    for (int s = 0; s < 4; s++) begin
      int up, dn;
      sel = 2'(s);
      up = lvl((s == 3) ? 3 : s + 1);
      dn = lvl((s == 0) ? 0 : s - 1);
      a_rts = 1'b0; man = 1'b1; cnt = CW'(20);
      step();
      chk("R2 rts", rts, 1'b1);
      a_rts = 1'b1; hold = 0;
      for (int dir = 0; dir < 2; dir++) begin
        for (int i = 0; i <= 32; i++) begin
          int c;
          c = (dir == 0) ? i : 32 - i;
          cnt = CW'(c);
          if (c >= up) hold = 1;
          else if (c < dn) hold = 0;
          step();
          chk((s == 0 || s == 3) ? "R6 rts" : (hold ? "R4 rts" : "R5 rts"), rts, hold[0]);
          chk("R3 irq", irq, (c >= lvl(s)) ? 1'b1 : 1'b0);
        end
      end
    end
    a_rts = 1'b0;

    // R10/R7: CTS latency with the strobe held high
    a_cts = 1'b1; bnd = 1'b1; cts = 1'b1;
    step(); step();
    chk("R10 early", permit, 1'b1);
    step();
    chk("R7 stop", permit, 1'b0);

    // R8: no change without a boundary strobe
    bnd = 1'b0; cts = 1'b0;
    for (int k = 0; k < 5; k++) begin
      step();
      chk("R8 hold", permit, 1'b0);
    end
    bnd = 1'b1;
    step();
    chk("R7 go", permit, 1'b1);

    cts = 1'b1; bnd = 1'b0;
    for (int k = 0; k < 4; k++) begin
      step();
      chk("R8 hold", permit, 1'b1);
    end
    bnd = 1'b1;
    step();
    chk("R7 stop", permit, 1'b0);

    // R9: auto-CTS off grants permit at the boundary
    a_cts = 1'b0;
    step();
    chk("R9 free", permit, 1'b1);
    for (int k = 0; k < 3; k++) begin
      step();
      chk("R9 free", permit, 1'b1);
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule